// File: doc/BRIEF.md
# Collision Backoff Countdown Controller

After a transmit collision this block works out how long to hold off before the next attempt, and then times that delay. It keeps a backoff load register that doubles and gains a low one on each collision. It cuts an 8-bit pseudo-random value out of a free-running time counter and masks that value with the load to get a countdown. An internal tick generator decrements the countdown. When the countdown is exhausted the block pulses an interface reset and, on the next cycle, a transmit start.

While the block waits, a post event cancels the retry. A packet that arrives with the receiver enabled is passed through an address filter. If the filter accepts it, the retry is abandoned so that the receiver can take the packet. If the filter rejects it, the wait goes on untouched. When the load has already reached its top bit, a collision is refused with a load-overflow abort and no retry is scheduled.

Top module: `collision_backoff`

## Requirements
- R1: After `rst_n` is released, `if_reset`, `tx_start` and `abort` are low and the load is zero. A first collision therefore gets a countdown of zero, and `tx_start` rises 2 cycles after the clock edge that sampled the collision.
- R2: Each collision accepted in idle replaces the load L with (L shifted left by one) OR 1. Starting from zero this gives 1, 3, 7, and so on up to all ones.
- R3: A collision seen in idle while the load's most significant bit is set raises `abort` for one cycle, 1 cycle after the sampling edge, with `abort_code` = 1 (load overflow). The load is left unchanged and no `tx_start` follows.
- R4: The random value is `free_clk[13:6]`, zero-extended. The countdown is that value ANDed with the load as it stood before the update made by the same collision.
- R5: The countdown drops by one every `TICK_CYCLES` clock cycles while the block waits. With countdown N, `tx_start` rises N*`TICK_CYCLES`+2 cycles after the sampling edge.
- R6: `if_reset` is high for exactly the one cycle right before `tx_start`, and `tx_start` is a one-cycle pulse.
- R7: `post_event` during the wait raises `abort` 1 cycle later with `abort_code` = 2, and no `tx_start` follows.
- R8: A `pkt_arrive` during the wait with `rx_enabled` high is accepted when `station_addr` is 0, when `pkt_dst` is 0, or when `pkt_dst` equals `station_addr`. An accepted packet raises `abort` 1 cycle later with `abort_code` = 3, and no `tx_start` follows.
- R9: A packet during the wait that the filter rejects, or any packet while `rx_enabled` is low, has no effect: `tx_start` comes at the same cycle as without it.
- R10: `reset_cmd` clears the load to zero and returns the block to idle.
- R11: A collision that arrives while the block is not idle is ignored. It changes neither the current countdown nor the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reset_cmd | input | 1 | Command reset: clears load, returns to idle |
| collision | input | 1 | Transmit collision event |
| free_clk | input | CLK_W | Free-running time counter used as random source |
| post_event | input | 1 | Status/post event from the interface |
| rx_enabled | input | 1 | Receiver armed for input under output |
| pkt_arrive | input | 1 | First word of an incoming packet is present |
| pkt_dst | input | ADDR_W | Destination address of the arriving packet |
| station_addr | input | ADDR_W | This station's address (0 = accept everything) |
| if_reset | output | 1 | One-cycle interface reset ahead of transmit |
| tx_start | output | 1 | One-cycle transmitter start |
| abort | output | 1 | One-cycle retry abort |
| abort_code | output | 2 | Abort cause: 1 overflow, 2 post, 3 receive |

## Verification
The hardest state to reach from the ports is a load with its top bit set. It can only be built by a chain of successful retries, and a retry only finishes once its countdown has run out. The bench uses a short tick period and a random field of zero while it builds the load, so each retry finishes at once. It then drives an all-ones random field, so each countdown equals the previous load, and this exposes every step of the growth. Events injected during the wait are placed at a fixed cycle count from the collision, so the effect on the start time is exact.

// File: rtl/cbk_pkg.sv
package cbk_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_IFRST = 2'd2,
      ST_GO    = 2'd3
   } bk_state_e;

   localparam logic [1:0] AB_LOAD_OVF = 2'd1;
   localparam logic [1:0] AB_POSTED   = 2'd2;
   localparam logic [1:0] AB_RX_TAKEN = 2'd3;
endpackage

// File: rtl/cbk_load.sv
module cbk_load #(
   parameter int LOAD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              grow,
   output logic [LOAD_W-1:0] load_q,
   output logic              full
);
   always_ff @(posedge clk) begin
      if (!rst_n)      load_q <= '0;
      else if (clear)  load_q <= '0;
      else if (grow)   load_q <= {load_q[LOAD_W-2:0], 1'b1};
   end

   assign full = load_q[LOAD_W-1];

   // R2: without a clear the load never shrinks
   assert_load_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> load_q >= $past(load_q));
   // R3: growth is never requested once the top bit is set
   assert_no_grow_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      grow |-> !full);
endmodule

// File: rtl/cbk_rand.sv
module cbk_rand #(
   parameter int CLK_W   = 16,
   parameter int RND_LSB = 6,
   parameter int RND_W   = 8,
   parameter int OUT_W   = 8
) (
   input  logic [RND_W-1:0] field,
   output logic [OUT_W-1:0] rnd_ext
);
   generate
      if (OUT_W == RND_W) begin : g_same
         assign rnd_ext = field;
      end else begin : g_ext
         assign rnd_ext = {{(OUT_W-RND_W){1'b0}}, field};
      end
      if (CLK_W < RND_LSB + RND_W) begin : g_bad_slice
         $error("random slice exceeds time counter width");
      end
   endgenerate
endmodule

// File: rtl/cbk_tick.sv
module cbk_tick #(
   parameter int PERIOD = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (PERIOD < 1) begin : g_bad_period
         $error("tick period must be at least one cycle");
      end
      if (PERIOD == 1) begin : g_every
         assign tick = run;
      end else begin : g_count
         localparam int TW = $clog2(PERIOD);
         localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);
         logic [TW-1:0] tcnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !run)  tcnt <= '0;
            else if (tcnt == LAST) tcnt <= '0;
            else                 tcnt <= tcnt + TW'(1);
         end
         assign tick = run && (tcnt == LAST);
         // R5: ticks are isolated single-cycle strobes
         assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/cbk_filter.sv
module cbk_filter #(
   parameter int ADDR_W    = 8,
   parameter bit FILTER_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] dst,
   input  logic [ADDR_W-1:0] station,
   output logic              accept
);
   generate
      if (FILTER_EN) begin : g_filter
         logic promisc, bcast, mine;
         assign promisc = (station == '0);
         assign bcast   = (dst == '0);
         assign mine    = (dst == station);
         assign accept  = promisc | bcast | mine;
      end else begin : g_all
         logic unused_addr;
         assign unused_addr = ^{dst, station};
         assign accept = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/collision_backoff.sv
module collision_backoff
   import cbk_pkg::*;
#(
   parameter int LOAD_W      = 8,
   parameter int CLK_W       = 16,
   parameter int RND_LSB     = 6,
   parameter int RND_W       = 8,
   parameter int ADDR_W      = 8,
   parameter int TICK_CYCLES = 9250,
   parameter bit FILTER_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reset_cmd,
   input  logic              collision,
   input  logic [CLK_W-1:0]  free_clk,
   input  logic              post_event,
   input  logic              rx_enabled,
   input  logic              pkt_arrive,
   input  logic [ADDR_W-1:0] pkt_dst,
   input  logic [ADDR_W-1:0] station_addr,
   output logic              if_reset,
   output logic              tx_start,
   output logic              abort,
   output logic [1:0]        abort_code
);
   typedef logic [LOAD_W-1:0] cnt_t;
   localparam cnt_t CNT_ONE = cnt_t'(1);

   generate
      if (LOAD_W < RND_W) begin : g_bad_load
         $error("load must be at least as wide as the random field");
      end
   endgenerate

   bk_state_e  state;
   cnt_t       cnt_q;
   cnt_t       load_q;
   cnt_t       rnd_ext;
   logic       load_full, tick, accept;
   logic       in_idle, in_wait, start_bk, ovf, rx_take;
   logic       abort_q;
   logic [1:0] code_q;
   logic       unused_clk_bits;

   assign unused_clk_bits = ^free_clk;

   assign in_idle  = (state == ST_IDLE);
   assign in_wait  = (state == ST_WAIT);
   assign start_bk = in_idle && collision && !reset_cmd && !load_full;
   assign ovf      = in_idle && collision && !reset_cmd && load_full;
   assign rx_take  = in_wait && pkt_arrive && rx_enabled && accept;

   cbk_load #(.LOAD_W(LOAD_W)) u_load (
      .clk(clk), .rst_n(rst_n), .clear(reset_cmd), .grow(start_bk),
      .load_q(load_q), .full(load_full));

   cbk_rand #(.CLK_W(CLK_W), .RND_LSB(RND_LSB), .RND_W(RND_W), .OUT_W(LOAD_W)) u_rand (
      .field(free_clk[RND_LSB +: RND_W]), .rnd_ext(rnd_ext));

   cbk_tick #(.PERIOD(TICK_CYCLES)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(in_wait), .tick(tick));

   cbk_filter #(.ADDR_W(ADDR_W), .FILTER_EN(FILTER_EN)) u_filter (
      .dst(pkt_dst), .station(station_addr), .accept(accept));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt_q   <= '0;
         abort_q <= 1'b0;
         code_q  <= 2'd0;
      end else begin
         abort_q <= 1'b0;
         if (reset_cmd) begin
            state <= ST_IDLE;
         end else begin
            case (state)
               ST_IDLE: begin
                  if (start_bk) begin
                     state <= ST_WAIT;
                     cnt_q <= rnd_ext & load_q;
                  end else if (ovf) begin
                     abort_q <= 1'b1;
                     code_q  <= AB_LOAD_OVF;
                  end
               end
               ST_WAIT: begin
                  if (post_event) begin
                     state   <= ST_IDLE;
                     abort_q <= 1'b1;
                     code_q  <= AB_POSTED;
                  end else if (rx_take) begin
                     state   <= ST_IDLE;
                     abort_q <= 1'b1;
                     code_q  <= AB_RX_TAKEN;
                  end else if (cnt_q == '0) begin
                     state <= ST_IFRST;
                  end else if (tick) begin
                     cnt_q <= cnt_q - CNT_ONE;
                  end
               end
               ST_IFRST: state <= ST_GO;
               default:  state <= ST_IDLE;
            endcase
         end
      end
   end

   assign if_reset   = (state == ST_IFRST);
   assign tx_start   = (state == ST_GO);
   assign abort      = abort_q;
   assign abort_code = code_q;

   // R6: the transmitter never starts without a reset the cycle before
   assert_reset_before_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> $past(if_reset));
   // R5: the countdown holds or steps down by exactly one while waiting
   assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wait && $past(in_wait)) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNT_ONE));
   // R3: an overflow abort only with the load's top bit set
   assert_ovf_needs_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && abort_code == AB_LOAD_OVF) |-> load_full);
   // R8: a receive abort follows an enabled packet arrival
   assert_rx_abort_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && abort_code == AB_RX_TAKEN) |-> $past(pkt_arrive && rx_enabled));
   // R7: a post abort follows a post event
   assert_post_abort_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && abort_code == AB_POSTED) |-> $past(post_event));
   // R6: at most one of the three outputs per cycle
   assert_outputs_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({if_reset, tx_start, abort}));
endmodule

// File: tb/collision_backoff_tb.sv
`timescale 1ns/1ps
module collision_backoff_tb;
   localparam int TICK = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reset_cmd = 1'b0, collision = 1'b0, post_event = 1'b0;
   logic       rx_enabled = 1'b0, pkt_arrive = 1'b0;
   logic [15:0] free_clk = '0;
   logic [7:0] pkt_dst = '0, station_addr = 8'h42;
   logic       if_reset, tx_start, abort;
   logic [1:0] abort_code;
   int checks = 0, fails = 0;

   always #2 clk = ~clk;

   collision_backoff #(.TICK_CYCLES(TICK)) u_dut (
      .clk(clk), .rst_n(rst_n), .reset_cmd(reset_cmd), .collision(collision),
      .free_clk(free_clk), .post_event(post_event), .rx_enabled(rx_enabled),
      .pkt_arrive(pkt_arrive), .pkt_dst(pkt_dst), .station_addr(station_addr),
      .if_reset(if_reset), .tx_start(tx_start), .abort(abort), .abort_code(abort_code));

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // kind: 0 packet, 1 post event, 2 collision
   task automatic run(input logic [7:0] rnd, input int inj_at, input int kind, input logic [7:0] dst,
                      output int cyc, output bit tx, output bit ab, output int code, output bit rstok);
      bit prev = 1'b0;
      @(negedge clk);
      free_clk = {2'b11, rnd, 6'b010101};
      collision = 1'b1;
      @(posedge clk);
      @(negedge clk);
      collision = 1'b0;
      cyc = 0; tx = 0; ab = 0; code = 0; rstok = 0;
      for (int g = 0; g < 3000; g++) begin
         if (tx_start) begin tx = 1; rstok = prev; break; end
         if (abort) begin ab = 1; code = int'(abort_code); break; end
         post_event = 1'b0; pkt_arrive = 1'b0; collision = 1'b0;
         if (cyc == inj_at) begin
            case (kind)
               0: begin pkt_arrive = 1'b1; pkt_dst = dst; end
               1: post_event = 1'b1;
               default: collision = 1'b1;
            endcase
         end
         prev = if_reset;
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end
      post_event = 1'b0; pkt_arrive = 1'b0; collision = 1'b0;
      if (!tx && !ab) chk(1'b0, "R5", "no completion", cyc, 0);
   endtask

   task automatic expect_start(input logic [7:0] rnd, input int inj_at, input int kind,
                               input logic [7:0] dst, input int exp_cyc, input string req);
      int cyc, code; bit tx, ab, rstok;
      run(rnd, inj_at, kind, dst, cyc, tx, ab, code, rstok);
      chk(tx && !ab, req, "tx_start seen", int'(tx), 1);
      chk(cyc == exp_cyc, req, "start latency", cyc, exp_cyc);
      chk(rstok, "R6", "if_reset before tx_start", int'(rstok), 1);
      @(posedge clk); @(negedge clk);
      chk(!tx_start && !if_reset, "R6", "one-cycle start pulse", int'(tx_start), 0);
   endtask

   task automatic expect_abort(input logic [7:0] rnd, input int inj_at, input int kind,
                               input logic [7:0] dst, input int exp_cyc, input int exp_code,
                               input string req);
      int cyc, code; bit tx, ab, rstok;
      run(rnd, inj_at, kind, dst, cyc, tx, ab, code, rstok);
      chk(ab && !tx, req, "abort seen", int'(ab), 1);
      chk(code == exp_code, req, "abort code", code, exp_code);
      chk(cyc == exp_cyc, req, "abort latency", cyc, exp_cyc);
      @(posedge clk); @(negedge clk);
      chk(!abort && !tx_start, req, "no start after abort", int'(tx_start), 0);
   endtask

   task automatic do_clear();
      @(negedge clk); reset_cmd = 1'b1;
      @(posedge clk); @(negedge clk); reset_cmd = 1'b0;
   endtask

   // clear, then build the load with zero random fields (each retry immediate)
   task automatic prep(input int n);
      do_clear();
      for (int i = 0; i < n; i++) expect_start(8'h00, -1, 0, 8'h00, 2, "R10");
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!if_reset && !tx_start && !abort, "R1", "outputs idle after reset",
          int'({if_reset, tx_start, abort}), 0);
      expect_start(8'hFF, -1, 0, 8'h00, 2, "R1");
   endtask

   task automatic t_growth();
      int l = 1;
      for (int i = 0; i < 7; i++) begin
         expect_start(8'hFF, -1, 0, 8'h00, l * TICK + 2, "R2");
         l = l * 2 + 1;
      end
   endtask

   task automatic t_overflow();
      expect_abort(8'hFF, -1, 0, 8'h00, 0, 1, "R3");
      expect_abort(8'h00, -1, 0, 8'h00, 0, 1, "R3");
   endtask

   task automatic t_clear();
      do_clear();
      expect_start(8'hFF, -1, 0, 8'h00, 2, "R10");
   endtask

   task automatic t_random();
      prep(7);
      expect_start(8'hA5, -1, 0, 8'h00, 37 * TICK + 2, "R4");
   endtask

   task automatic t_post();
      prep(2);
      expect_abort(8'hFF, 5, 1, 8'h00, 6, 2, "R7");
   endtask

   task automatic t_rx_accept();
      rx_enabled = 1'b1;
      station_addr = 8'h42;
      prep(2);
      expect_abort(8'hFF, 4, 0, 8'h42, 5, 3, "R8");
      prep(2);
      expect_abort(8'hFF, 4, 0, 8'h00, 5, 3, "R8");
      station_addr = 8'h00;
      prep(2);
      expect_abort(8'hFF, 4, 0, 8'h99, 5, 3, "R8");
      station_addr = 8'h42;
   endtask

   task automatic t_rx_ignore();
      rx_enabled = 1'b1;
      prep(2);
      expect_start(8'hFF, 4, 0, 8'h17, 3 * TICK + 2, "R9");
      rx_enabled = 1'b0;
      prep(2);
      expect_start(8'hFF, 4, 0, 8'h42, 3 * TICK + 2, "R9");
   endtask

   task automatic t_busy_collision();
      prep(2);
      expect_start(8'hFF, 2, 2, 8'h00, 3 * TICK + 2, "R11");
      expect_start(8'hFF, -1, 0, 8'h00, 7 * TICK + 2, "R11");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_growth();
      t_overflow();
      t_clear();
      t_random();
      t_post();
      t_rx_accept();
      t_rx_ignore();
      t_busy_collision();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R5", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule